// File: doc/BRIEF.md
# Receive Timeslot Timing Generator

This block walks along a received DS1 or E1 serial payload stream one bit at a time and produces the timing strobes that downstream terminal logic needs. It counts bit positions inside the frame, reports which 8-bit timeslot the current bit belongs to, and marks the last bit of every timeslot. It also produces a fractional-payload strobe for timeslots picked by a 32-bit mask, and in E1 mode a pulse on the first bit of each 16-frame CAS multiframe.

The block runs on a fast system clock. A one-cycle `bit_en` tick marks each received bit. `frame_start` comes with the tick of the first bit of a frame. `mf_start` comes together with `frame_start` on frame 0 of a multiframe. Every output is registered on the tick of the bit it describes and keeps its value until the next tick. The one exception is the gapped fractional pulse, which lasts for only one system cycle.

Top module: `rx_slot_timer`

## Requirements
- R1: In E1 mode (`e1_mode`=1) a frame has 256 bits, numbered 0 to 255 from frame start. Bit p belongs to timeslot p/8, and `slot_num` shows that timeslot from the tick of the bit onward.
- R2: In DS1 mode (`e1_mode`=0) a frame has 193 bits. Bit 0 is the framing bit: during it `slot_strobe` and `frac_out` are low and `slot_num` keeps its earlier value. Bit p, for p from 1 to 192, belongs to timeslot (p-1)/8.
- R3: `slot_strobe` is high for exactly the bit period of the eighth (last, least significant) bit of each timeslot, and low for every other bit.
- R4: `slot_num` takes its new value on the first bit of a timeslot and does not change while `slot_strobe` is high.
- R5: A tick with `frame_start` high restarts the count at bit 0. Without `frame_start`, the count wraps from the last bit (255 in E1, 192 in DS1) to bit 0.
- R6: With `frac_on`=1 and `frac_gapped`=0, `frac_out` is a level that is high during every bit of the timeslots N whose `slot_mask[N]` is 1.
- R7: With `frac_on`=1 and `frac_gapped`=1, `frac_out` pulses high for one system cycle, in the cycle after the tick of each bit of a selected timeslot. It is low at all other times. Ticks must be at least two system cycles apart.
- R8: With `frac_on`=0, `frac_out` stays low. In DS1 mode, mask bits 24 to 31 have no effect.
- R9: Each frame boundary advances a 4-bit frame counter modulo 16. A boundary is either `frame_start` or a wrap. `frame_start` together with `mf_start` sets the counter to frame 0. In E1 mode `mf_sync` is high for the bit period of bit 0 of frame 0, and never together with `slot_strobe`.
- R10: `mf_sync` stays low in DS1 mode and whenever `ccs_sel`=1.
- R11: `slot_num`, `slot_strobe` and `mf_sync` change only in the cycle that follows a `bit_en` tick. The enable-style `frac_out` also changes only then.
- R12: After reset all outputs are 0. The first tick is taken as bit 0 of frame 0 even when `frame_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle tick per received bit |
| frame_start | input | 1 | With the tick, the bit is bit 0 of a frame |
| mf_start | input | 1 | With frame_start, the frame is frame 0 of a multiframe |
| e1_mode | input | 1 | 1 = E1 (256-bit frame), 0 = DS1 (193-bit frame) |
| frac_on | input | 1 | Enables the fractional output |
| frac_gapped | input | 1 | 1 = gapped pulse style, 0 = enable level style |
| ccs_sel | input | 1 | Common channel signaling selected; suppresses mf_sync |
| slot_mask | input | 32 | Bit N selects timeslot N for fractional output |
| slot_num | output | 5 | Timeslot of the current bit |
| slot_strobe | output | 1 | High during the last bit of each timeslot |
| frac_out | output | 1 | Fractional payload pulse or enable |
| mf_sync | output | 1 | E1 CAS multiframe first-bit pulse |

## Verification
A frame restart can land on a tick where the running count would otherwise have produced a timeslot's last bit and its strobe. The restart must win: that bit becomes bit 0, the strobe stays low, and the multiframe counter steps. The bench forces `frame_start` on the eighth bit of a timeslot as a directed case, and also mixes random mid-frame restarts into the random phase. The bench model recomputes every output for each bit and compares it with the design.

// File: rtl/rx_slot_timer.sv
module rx_slot_timer #(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int DS1_SLOTS = 24,
  parameter int MF_FRAMES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_en,
  input  logic                        frame_start,
  input  logic                        mf_start,
  input  logic                        e1_mode,
  input  logic                        frac_on,
  input  logic                        frac_gapped,
  input  logic                        ccs_sel,
  input  logic [E1_SLOTS-1:0]         slot_mask,
  output logic [$clog2(E1_SLOTS)-1:0] slot_num,
  output logic                        slot_strobe,
  output logic                        frac_out,
  output logic                        mf_sync
);
  localparam int E1_LAST  = SLOT_BITS * E1_SLOTS - 1;
  localparam int DS1_LAST = SLOT_BITS * DS1_SLOTS;
  localparam int POS_W    = $clog2(E1_LAST + 1);
  localparam int BIT_W    = $clog2(SLOT_BITS);
  localparam int SN_W     = $clog2(E1_SLOTS);
  localparam int FC_W     = $clog2(MF_FRAMES);

  logic [POS_W-1:0] pos, npos, pidx, last;
  logic [SN_W-1:0]  nslot;
  logic [BIT_W-1:0] nbit;
  logic [FC_W-1:0]  fc, nfc;
  logic             fbit, sel, bnd;
  logic             gap_q, frac_lvl, frac_pls;

  assign last  = e1_mode ? POS_W'(E1_LAST) : POS_W'(DS1_LAST);
  assign npos  = (frame_start || pos >= last) ? '0 : pos + 1'b1;
  assign bnd   = (npos == '0);
  assign fbit  = !e1_mode && bnd;
  assign pidx  = e1_mode ? npos : npos - 1'b1;
  assign nslot = pidx[POS_W-1:BIT_W];
  assign nbit  = pidx[BIT_W-1:0];
  assign sel   = frac_on && !fbit && slot_mask[nslot];
  assign nfc   = !bnd ? fc : (frame_start && mf_start) ? '0 : fc + 1'b1;

  assign frac_out = gap_q ? frac_pls : frac_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos         <= '1;
      fc          <= '1;
      slot_num    <= '0;
      slot_strobe <= 1'b0;
      mf_sync     <= 1'b0;
      gap_q       <= 1'b0;
      frac_lvl    <= 1'b0;
      frac_pls    <= 1'b0;
    end else begin
      frac_pls <= bit_en && sel;
      if (bit_en) begin
        pos         <= npos;
        fc          <= nfc;
        if (!fbit) slot_num <= nslot;
        slot_strobe <= !fbit && (nbit == BIT_W'(SLOT_BITS - 1));
        mf_sync     <= e1_mode && !ccs_sel && bnd && (nfc == '0);
        gap_q       <= frac_gapped;
        frac_lvl    <= sel;
      end
    end
  end
endmodule

// File: rtl/rx_slot_timer_chk.sv
module rx_slot_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       e1_mode,
  input logic       frac_on,
  input logic       ccs_sel,
  input logic [4:0] slot_num,
  input logic       slot_strobe,
  input logic       frac_out,
  input logic       mf_sync
);
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(slot_num) && $stable(slot_strobe) && $stable(mf_sync))); // R11
  AST_SLOT_STABLE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_strobe) |-> $stable(slot_num)); // R4
  AST_FRAC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frac_out) |-> $past(bit_en && frac_on)); // R8
  AST_MF_E1_CAS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_sync) |-> $past(bit_en && e1_mode && !ccs_sel)); // R10
  AST_MF_NOT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mf_sync |-> !slot_strobe); // R9
endmodule

bind rx_slot_timer rx_slot_timer_chk u_chk (.*);

// File: tb/tb_rx_slot_timer.sv
module tb_rx_slot_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, frame_start = 0, mf_start = 0;
  logic e1_mode = 1, frac_on = 0, frac_gapped = 0, ccs_sel = 0;
  logic [31:0] slot_mask = '0;
  logic [4:0] slot_num;
  logic slot_strobe, frac_out, mf_sync;

  int n_cmp = 0, n_bad = 0;
  int mpos = -1, mfc = 15, eslot = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_slot_timer dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int frame_len(input logic e1);
    return e1 ? 256 : 193;
  endfunction

  task automatic do_tick(input logic fs, input logic ms);
    int idx;
    bit fb, estr, esel, emf;
    string st, ft, mt;
    @(negedge clk);
    bit_en = 1; frame_start = fs; mf_start = ms;
    if (fs || mpos >= frame_len(e1_mode) - 1) mpos = 0; else mpos++;
    if (mpos == 0) mfc = (fs && ms) ? 0 : (mfc + 1) % 16;
    fb   = !e1_mode && mpos == 0;
    idx  = e1_mode ? mpos : mpos - 1;
    if (!fb) eslot = idx / 8;
    estr = !fb && (idx % 8 == 7);
    esel = frac_on && !fb && slot_mask[eslot];
    emf  = e1_mode && !ccs_sel && mpos == 0 && mfc == 0;
    st = (mpos == 0) ? "R5" : (e1_mode ? "R1" : "R2");
    ft = !frac_on ? "R8" : (frac_gapped ? "R7" : "R6");
    mt = (ccs_sel || !e1_mode) ? "R10" : "R9";
    @(negedge clk);
    bit_en = 0; frame_start = 0; mf_start = 0;
    chk(st, int'(slot_num), eslot);
    chk("R3", int'(slot_strobe), int'(estr));
    chk(ft, int'(frac_out), int'(esel));
    chk(mt, int'(mf_sync), int'(emf));
    @(negedge clk);
    chk(estr ? "R4" : "R11", int'(slot_num), eslot);
    chk("R11", int'(slot_strobe), int'(estr));
    chk("R11", int'(mf_sync), int'(emf));
    chk(ft, int'(frac_out), int'(esel && !frac_gapped));
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic run_frame(input logic ms);
    do_tick(1, ms);
    repeat (frame_len(e1_mode) - 1) do_tick(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12", int'(slot_num), 0);
    chk("R12", int'(slot_strobe), 0);
    chk("R12", int'(frac_out), 0);
    chk("R12", int'(mf_sync), 0);

    // E1 free-running from reset, enable style
    frac_on = 1; slot_mask = $urandom();
    do_tick(0, 0);
    chk("R12", int'(mf_sync), 1);
    repeat (300) do_tick(0, 0);

    // E1 full multiframe plus one
    slot_mask = $urandom();
    run_frame(1);
    repeat (16) run_frame(0);

    // gapped style
    frac_gapped = 1;
    slot_mask = $urandom();
    run_frame(1);
    slot_mask = 32'h8000_0001;
    run_frame(0);

    // restart on the last bit of a timeslot
    frac_gapped = 0;
    do_tick(1, 1);
    repeat (6) do_tick(0, 0);
    do_tick(1, 0);
    chk("R5", int'(slot_strobe), 0);
    repeat (20) do_tick(0, 0);

    // CCS suppresses multiframe pulse
    ccs_sel = 1;
    run_frame(1);
    ccs_sel = 0;
    frac_on = 0; slot_mask = '1;
    run_frame(1);

    // DS1 framed, then upper mask bits flipped, then free-run wrap
    e1_mode = 0; frac_on = 1;
    slot_mask = 32'h0000_0000 | ($urandom() & 32'h00FF_FFFF);
    run_frame(1);
    run_frame(0);
    slot_mask = slot_mask | 32'hFF00_0000;
    run_frame(1);
    frac_gapped = 1;
    do_tick(1, 0);
    repeat (2 * 193) do_tick(0, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 299) == 0) begin
        e1_mode     = $urandom_range(0, 1);
        frac_on     = $urandom_range(0, 3) != 0;
        frac_gapped = $urandom_range(0, 1);
        ccs_sel     = $urandom_range(0, 3) == 0;
        slot_mask   = $urandom();
        do_tick(1, $urandom_range(0, 1));
      end else begin
        do_tick(0, 0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule